// File: doc/BRIEF.md
# Run-time frame configuration register bank

This block gives a host a small write/read register window for three video settings that may change while pixels are flowing: the frame width, the frame height and a keep (output hold) flag. Host writes land in shadow copies only. The video logic works from a separate set of working copies, which change only at frame boundaries, so a half-written configuration never reaches the pixel path.

The host loads the shadow copies and then sets a commit bit. From that point every host write is refused until the block has finished the commit. The next input frame start copies width and height into the working set and clears the commit bit. The keep flag is staged at the same moment but becomes active only at the following output frame start. The output side also samples the working width and height, each plus one, at every output frame start, so downstream logic sees the real pixel counts for the frame it is producing. Width and height values outside the legal range are clamped when written. Everything runs on one clock.

Top module: `frame_cfg_regs`

## Requirements
- R1: After reset the shadow width reads 719, shadow height 479, keep 0 and commit 0. The working width and height are 719 and 479, the active keep is 0, and the sampled sizes are 720 and 480.
- R2: The register is selected by paddr[4:2]: 0 = width minus one, 1 = height minus one, 2 = keep (bit 0 only), 3 = commit (bit 0). Other indices, and any address with paddr[1:0] nonzero, read as 0 and writes to them change nothing.
- R3: prdat shows the value of the register addressed in the previous clock cycle. It does not change until the clock edge that follows an address change.
- R4: While the commit bit is 1, every host write is ignored, including writes to the commit bit itself.
- R5: Writing 1 to the commit bit sets it. At the first input frame start that follows, the working width and height take the shadow values and the commit bit returns to 0 on that same edge.
- R6: A register that was not written before a commit passes its earlier shadow value to the working set unchanged.
- R7: A committed keep value drives the keep output only from the first output frame start after the commit. An output frame start that comes before the commit leaves the keep output unchanged.
- R8: A width or height write below 63 stores 63. A write above the configured maximum minus one (1919 for width, 1079 for height by default) stores that maximum minus one.
- R9: The sampled width and height outputs equal the working values plus one, taken at each output frame start, and hold between output frame starts.
- R10: An input frame start with no commit pending leaves the working width and height unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrite | input | 1 | Host write strobe |
| paddr | input | 5 | Host byte address |
| pwdat | input | DATA_W (32) | Host write data |
| prdat | output | DATA_W (32) | Host read data, one cycle after the address |
| in_frame_start | input | 1 | Pulse at the first pixel of an input frame |
| out_frame_start | input | 1 | Pulse at the first pixel of an output frame |
| work_width_m1 | output | FIELD_W (16) | Working frame width minus one |
| work_height_m1 | output | FIELD_W (16) | Working frame height minus one |
| keep_active | output | 1 | Keep flag in force for the current output frame |
| cur_width | output | FIELD_W (16) | Output frame width, sampled at output frame start |
| cur_height | output | FIELD_W (16) | Output frame height, sampled at output frame start |

## Verification
The properties assume that both frame-start inputs and the host strobe are synchronous to the single clock and sampled only at rising edges. They also assume that the host address and data are stable whenever pwrite is high. The bench changes every input on the falling edge and drives each frame start as a pulse one cycle long. It never overlaps a commit with a host write, so every expected value follows directly from the order of edges. The window properties check only that working state moves at frame starts, so they place no limit on how often frames arrive.

// File: rtl/frame_cfg_pkg.sv
package frame_cfg_pkg;

   localparam int unsigned MIN_DIM_M1 = 63;

   typedef enum logic [2:0] {
      IDX_WIDTH  = 3'd0,
      IDX_HEIGHT = 3'd1,
      IDX_KEEP   = 3'd2,
      IDX_COMMIT = 3'd3
   } cfg_idx_e;

   // bound a dimension (minus one) to [MIN_DIM_M1, hi_m1]
   function automatic logic [31:0] clamp_dim(input logic [31:0] v, input int unsigned hi_m1);
      logic [31:0] r;
      if (v < 32'(MIN_DIM_M1))
         r = 32'(MIN_DIM_M1);
      else if (v > 32'(hi_m1))
         r = 32'(hi_m1);
      else
         r = v;
      return r;
   endfunction

endpackage

// File: rtl/cfg_host_port.sv
module cfg_host_port
   import frame_cfg_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned FIELD_W    = 16,
   parameter int unsigned MAX_WIDTH  = 1920,
   parameter int unsigned MAX_HEIGHT = 1080,
   parameter int unsigned RST_W_M1   = 719,
   parameter int unsigned RST_H_M1   = 479
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pwrite,
   input  logic [4:0]         paddr,
   input  logic [DATA_W-1:0]  pwdat,
   input  logic               commit_pending,
   output logic [FIELD_W-1:0] shadow_w,
   output logic [FIELD_W-1:0] shadow_h,
   output logic               shadow_keep,
   output logic               arm_commit,
   output logic [DATA_W-1:0]  prdat
);

   localparam int unsigned HI_W_M1 = MAX_WIDTH - 1;
   localparam int unsigned HI_H_M1 = MAX_HEIGHT - 1;

   logic        lane_ok;
   logic [31:0] wd32;
   logic [31:0] rd_word;
   cfg_idx_e    idx;
   logic        wr_ok;

   // lane decode depends on the bus width
   generate
      if (DATA_W >= 32) begin : g_lane32
         always_comb lane_ok = (paddr[1:0] == 2'b00);
      end else begin : g_lane16
         // bit 0 must be zero; the upper halfword of every field is empty
         always_comb lane_ok = !paddr[0] && !paddr[1];
      end
   endgenerate

   always_comb begin
      wd32 = '0;
      wd32[DATA_W-1:0] = pwdat;
   end

   assign idx   = cfg_idx_e'(paddr[4:2]);
   assign wr_ok = pwrite && !commit_pending && lane_ok;
   assign arm_commit = wr_ok && (idx == IDX_COMMIT) && wd32[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_w    <= FIELD_W'(RST_W_M1);
         shadow_h    <= FIELD_W'(RST_H_M1);
         shadow_keep <= 1'b0;
      end else if (wr_ok) begin
         case (idx)
            IDX_WIDTH:  shadow_w    <= FIELD_W'(clamp_dim(wd32, HI_W_M1));
            IDX_HEIGHT: shadow_h    <= FIELD_W'(clamp_dim(wd32, HI_H_M1));
            IDX_KEEP:   shadow_keep <= wd32[0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_word = '0;
      if (lane_ok) begin
         case (idx)
            IDX_WIDTH:  rd_word = 32'(shadow_w);
            IDX_HEIGHT: rd_word = 32'(shadow_h);
            IDX_KEEP:   rd_word = {31'd0, shadow_keep};
            IDX_COMMIT: rd_word = {31'd0, commit_pending};
            default:    rd_word = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prdat <= '0;
      else
         prdat <= rd_word[DATA_W-1:0];
   end

endmodule

// File: rtl/cfg_commit_ctrl.sv
module cfg_commit_ctrl #(
   parameter int unsigned FIELD_W  = 16,
   parameter int unsigned RST_W_M1 = 719,
   parameter int unsigned RST_H_M1 = 479
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               arm_commit,
   input  logic               in_frame_start,
   input  logic [FIELD_W-1:0] shadow_w,
   input  logic [FIELD_W-1:0] shadow_h,
   input  logic               shadow_keep,
   output logic               commit_pending,
   output logic [FIELD_W-1:0] work_w,
   output logic [FIELD_W-1:0] work_h,
   output logic               keep_staged
);

   logic take;
   assign take = commit_pending && in_frame_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         commit_pending <= 1'b0;
      else if (arm_commit)
         commit_pending <= 1'b1;
      else if (take)
         commit_pending <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_w      <= FIELD_W'(RST_W_M1);
         work_h      <= FIELD_W'(RST_H_M1);
         keep_staged <= 1'b0;
      end else if (take) begin
         work_w      <= shadow_w;
         work_h      <= shadow_h;
         keep_staged <= shadow_keep;
      end
   end

endmodule

// File: rtl/cfg_out_sampler.sv
module cfg_out_sampler #(
   parameter int unsigned FIELD_W  = 16,
   parameter int unsigned RST_W_M1 = 719,
   parameter int unsigned RST_H_M1 = 479
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               out_frame_start,
   input  logic [FIELD_W-1:0] work_w,
   input  logic [FIELD_W-1:0] work_h,
   input  logic               keep_staged,
   output logic               keep_active,
   output logic [FIELD_W-1:0] cur_w,
   output logic [FIELD_W-1:0] cur_h
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         keep_active <= 1'b0;
         cur_w       <= FIELD_W'(RST_W_M1 + 1);
         cur_h       <= FIELD_W'(RST_H_M1 + 1);
      end else if (out_frame_start) begin
         keep_active <= keep_staged;
         cur_w       <= work_w + FIELD_W'(1);
         cur_h       <= work_h + FIELD_W'(1);
      end
   end

endmodule

// File: rtl/frame_cfg_regs.sv
module frame_cfg_regs #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned FIELD_W    = 16,
   parameter int unsigned MAX_WIDTH  = 1920,
   parameter int unsigned MAX_HEIGHT = 1080,
   parameter int unsigned RST_W_M1   = 719,
   parameter int unsigned RST_H_M1   = 479
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pwrite,
   input  logic [4:0]         paddr,
   input  logic [DATA_W-1:0]  pwdat,
   output logic [DATA_W-1:0]  prdat,
   input  logic               in_frame_start,
   input  logic               out_frame_start,
   output logic [FIELD_W-1:0] work_width_m1,
   output logic [FIELD_W-1:0] work_height_m1,
   output logic               keep_active,
   output logic [FIELD_W-1:0] cur_width,
   output logic [FIELD_W-1:0] cur_height
);

   // elaboration-time parameter checks
   generate
      if (!(DATA_W == 16 || DATA_W == 32)) begin : g_bad_bus
         $error("DATA_W must be 16 or 32");
      end
      if (FIELD_W > DATA_W) begin : g_bad_field
         $error("FIELD_W must not exceed DATA_W");
      end
      if (MAX_WIDTH < 64 || MAX_HEIGHT < 64) begin : g_bad_min
         $error("maximum frame size must be at least 64");
      end
      if (MAX_WIDTH > (1 << FIELD_W) || MAX_HEIGHT > (1 << FIELD_W)) begin : g_bad_max
         $error("maximum frame size does not fit FIELD_W");
      end
      if (RST_W_M1 < 63 || RST_W_M1 >= MAX_WIDTH || RST_H_M1 < 63 || RST_H_M1 >= MAX_HEIGHT) begin : g_bad_rst
         $error("reset frame size out of legal range");
      end
   endgenerate

   logic [FIELD_W-1:0] shadow_w;
   logic [FIELD_W-1:0] shadow_h;
   logic               shadow_keep;
   logic               arm_commit;
   logic               commit_pending;
   logic               keep_staged;

   cfg_host_port #(
      .DATA_W(DATA_W), .FIELD_W(FIELD_W),
      .MAX_WIDTH(MAX_WIDTH), .MAX_HEIGHT(MAX_HEIGHT),
      .RST_W_M1(RST_W_M1), .RST_H_M1(RST_H_M1)
   ) u_host (
      .clk(clk), .rst_n(rst_n),
      .pwrite(pwrite), .paddr(paddr), .pwdat(pwdat),
      .commit_pending(commit_pending),
      .shadow_w(shadow_w), .shadow_h(shadow_h), .shadow_keep(shadow_keep),
      .arm_commit(arm_commit), .prdat(prdat)
   );

   cfg_commit_ctrl #(
      .FIELD_W(FIELD_W), .RST_W_M1(RST_W_M1), .RST_H_M1(RST_H_M1)
   ) u_commit (
      .clk(clk), .rst_n(rst_n),
      .arm_commit(arm_commit), .in_frame_start(in_frame_start),
      .shadow_w(shadow_w), .shadow_h(shadow_h), .shadow_keep(shadow_keep),
      .commit_pending(commit_pending),
      .work_w(work_width_m1), .work_h(work_height_m1),
      .keep_staged(keep_staged)
   );

   cfg_out_sampler #(
      .FIELD_W(FIELD_W), .RST_W_M1(RST_W_M1), .RST_H_M1(RST_H_M1)
   ) u_out (
      .clk(clk), .rst_n(rst_n),
      .out_frame_start(out_frame_start),
      .work_w(work_width_m1), .work_h(work_height_m1),
      .keep_staged(keep_staged),
      .keep_active(keep_active),
      .cur_w(cur_width), .cur_h(cur_height)
   );

endmodule

// File: rtl/frame_cfg_regs_chk.sv
module frame_cfg_regs_chk #(
   parameter int unsigned FIELD_W    = 16,
   parameter int unsigned MAX_WIDTH  = 1920,
   parameter int unsigned MAX_HEIGHT = 1080
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_fs,
   input logic               out_fs,
   input logic               pending,
   input logic [FIELD_W-1:0] sh_w,
   input logic [FIELD_W-1:0] sh_h,
   input logic               sh_k,
   input logic [FIELD_W-1:0] wk_w,
   input logic [FIELD_W-1:0] wk_h,
   input logic               k_stage,
   input logic               k_act,
   input logic [FIELD_W-1:0] c_w,
   input logic [FIELD_W-1:0] c_h
);

   p_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pending |=> ($stable(sh_w) && $stable(sh_h) && $stable(sh_k)));

   p_commit_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && in_fs) |=> (wk_w == $past(sh_w) && wk_h == $past(sh_h)));

   p_commit_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && in_fs) |=> !pending);

   p_keep_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_fs |=> $stable(k_act));

   p_keep_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_fs |=> (k_act == $past(k_stage)));

   p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sh_w) >= 63 && int'(sh_w) <= int'(MAX_WIDTH) - 1 &&
       int'(sh_h) >= 63 && int'(sh_h) <= int'(MAX_HEIGHT) - 1));

   p_cur_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_fs |=> (c_w == $past(wk_w) + FIELD_W'(1) && c_h == $past(wk_h) + FIELD_W'(1)));

   p_cur_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_fs |=> ($stable(c_w) && $stable(c_h)));

   p_work_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(pending && in_fs) |=> ($stable(wk_w) && $stable(wk_h)));

endmodule

bind frame_cfg_regs frame_cfg_regs_chk #(
   .FIELD_W(FIELD_W), .MAX_WIDTH(MAX_WIDTH), .MAX_HEIGHT(MAX_HEIGHT)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .in_fs(in_frame_start), .out_fs(out_frame_start),
   .pending(commit_pending),
   .sh_w(shadow_w), .sh_h(shadow_h), .sh_k(shadow_keep),
   .wk_w(work_width_m1), .wk_h(work_height_m1),
   .k_stage(keep_staged), .k_act(keep_active),
   .c_w(cur_width), .c_h(cur_height)
);

// File: tb/test_frame_cfg_regs.sv
`timescale 1ns/1ps
module test_frame_cfg_regs;

   localparam int unsigned DW = 32;
   localparam int unsigned FW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pwrite = 1'b0;
   logic [4:0]    paddr = '0;
   logic [DW-1:0] pwdat = '0;
   logic [DW-1:0] prdat;
   logic          in_frame_start = 1'b0;
   logic          out_frame_start = 1'b0;
   logic [FW-1:0] work_width_m1;
   logic [FW-1:0] work_height_m1;
   logic          keep_active;
   logic [FW-1:0] cur_width;
   logic [FW-1:0] cur_height;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   frame_cfg_regs i_frame_cfg_regs (
      .clk(clk), .rst_n(rst_n),
      .pwrite(pwrite), .paddr(paddr), .pwdat(pwdat), .prdat(prdat),
      .in_frame_start(in_frame_start), .out_frame_start(out_frame_start),
      .work_width_m1(work_width_m1), .work_height_m1(work_height_m1),
      .keep_active(keep_active),
      .cur_width(cur_width), .cur_height(cur_height)
   );

   // {write addr, write data, read addr, expected read}
   localparam int NVEC = 12;
   localparam logic [73:0] VEC_TAB [NVEC] = '{
      {5'h00, 32'd100,  5'h00, 32'd100},
      {5'h00, 32'd10,   5'h00, 32'd63},
      {5'h00, 32'd5000, 5'h00, 32'd1919},
      {5'h04, 32'd63,   5'h04, 32'd63},
      {5'h04, 32'd2000, 5'h04, 32'd1079},
      {5'h08, 32'd3,    5'h08, 32'd1},
      {5'h08, 32'd2,    5'h08, 32'd0},
      {5'h01, 32'd55,   5'h00, 32'd1919},
      {5'h10, 32'd77,   5'h10, 32'd0},
      {5'h0C, 32'd0,    5'h0C, 32'd0},
      {5'h04, 32'd62,   5'h04, 32'd63},
      {5'h00, 32'd1919, 5'h00, 32'd1919}
   };

   task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      pwrite = 1'b1;
      paddr  = a;
      pwdat  = d;
      @(negedge clk);
      pwrite = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      paddr = a;
      @(negedge clk);
      d = prdat;
   endtask

   task automatic pulse_in();
      @(negedge clk);
      in_frame_start = 1'b1;
      @(negedge clk);
      in_frame_start = 1'b0;
   endtask

   task automatic pulse_out();
      @(negedge clk);
      out_frame_start = 1'b1;
      @(negedge clk);
      out_frame_start = 1'b0;
   endtask

   initial begin
      #500000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(5'h00, v); chk(v, 32'd719, "R1 shadow width");
      rd(5'h04, v); chk(v, 32'd479, "R1 shadow height");
      rd(5'h08, v); chk(v, 32'd0,   "R1 shadow keep");
      rd(5'h0C, v); chk(v, 32'd0,   "R1 commit bit");
      chk(32'(work_width_m1),  32'd719, "R1 working width");
      chk(32'(work_height_m1), 32'd479, "R1 working height");
      chk(32'(keep_active),    32'd0,   "R1 keep output");
      chk(32'(cur_width),      32'd720, "R1 sampled width");
      chk(32'(cur_height),     32'd480, "R1 sampled height");

      // R2 R8 table of writes and readbacks
      for (int i = 0; i < NVEC; i++) begin
         wr(VEC_TAB[i][73:69], VEC_TAB[i][68:37]);
         rd(VEC_TAB[i][36:32], v);
         chk(v, VEC_TAB[i][31:0], $sformatf("R2 R8 vector %0d", i));
      end

      // R3 read latency: address change shows only after the next edge
      @(negedge clk); paddr = 5'h00;
      @(negedge clk); chk(prdat, 32'd1919, "R3 first read");
      paddr = 5'h04;
      #1 chk(prdat, 32'd1919, "R3 holds before edge");
      @(negedge clk); chk(prdat, 32'd63, "R3 new address after edge");

      // R10 frame start without a pending commit
      wr(5'h00, 32'd1023);
      wr(5'h04, 32'd599);
      wr(5'h08, 32'd1);
      pulse_in();
      chk(32'(work_width_m1), 32'd719, "R10 width unchanged");
      chk(32'(work_height_m1), 32'd479, "R10 height unchanged");

      // R5 arm commit, R4 writes locked
      wr(5'h0C, 32'd1);
      rd(5'h0C, v); chk(v, 32'd1, "R5 commit bit set");
      wr(5'h00, 32'd200);
      wr(5'h0C, 32'd0);
      rd(5'h00, v); chk(v, 32'd1023, "R4 width write ignored");
      rd(5'h0C, v); chk(v, 32'd1, "R4 commit write ignored");
      chk(32'(work_width_m1), 32'd719, "R5 no change before frame start");
      pulse_in();
      chk(32'(work_width_m1), 32'd1023, "R5 width committed");
      chk(32'(work_height_m1), 32'd599, "R5 height committed");
      rd(5'h0C, v); chk(v, 32'd0, "R5 commit bit cleared");
      chk(32'(keep_active), 32'd0, "R7 keep waits for output frame");
      chk(32'(cur_width), 32'd720, "R9 sampled width holds");
      pulse_out();
      chk(32'(keep_active), 32'd1, "R7 keep at output frame");
      chk(32'(cur_width), 32'd1024, "R9 sampled width");
      chk(32'(cur_height), 32'd600, "R9 sampled height");

      // R6 only height written before commit
      wr(5'h04, 32'd299);
      wr(5'h0C, 32'd1);
      pulse_in();
      chk(32'(work_width_m1), 32'd1023, "R6 width carried");
      chk(32'(work_height_m1), 32'd299, "R6 height committed");

      // R7 output frame before commit leaves keep as is
      wr(5'h08, 32'd0);
      wr(5'h0C, 32'd1);
      pulse_out();
      chk(32'(keep_active), 32'd1, "R7 keep before commit");
      chk(32'(cur_height), 32'd300, "R9 resampled height");
      pulse_in();
      chk(32'(keep_active), 32'd1, "R7 keep after commit only");
      pulse_out();
      chk(32'(keep_active), 32'd0, "R7 keep cleared at output frame");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule